// File: doc/BRIEF.md
# Dual-Mode Serial Shifter with Two-Wire Bus Support

This block shifts serial frames in one of two modes. In synchronous mode it sends and receives eight-bit words, least significant bit first, and drives the data pin push-pull. In two-wire mode it uses the data pin as an open-drain line next to an external bit clock. It shifts nine-bit frames, most significant bit first: eight data bits and then one acknowledge bit. Both pins pass through a glitch filter with a selectable width. Both modes are clocked by the filtered clock pin. The clock source that drives that pin lies outside the block.

Software writes a byte on the transmit stream port and reads received bytes from the receive stream port. Either bus side starts a frame, and the data bits go out as SCL falls. To receive in two-wire mode, software sends 0xFF so that the line stays released. Three event pulses and a DMA request change meaning with the mode. In two-wire mode the block also tracks start and stop conditions and a bus-busy flag. It keeps a sticky arbitration-lost flag and can hold the clock low after the acknowledge bit.

The transmit port accepts a byte only when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low while a frame is in flight or while the block is disabled. The receive port holds `rx_valid_o` and `rx_data_o` until `rx_ready_i` is seen high. If a frame completes before the held byte is taken, the new byte replaces the old one.

Top module: `sio_i2c_shifter`

## Requirements
- R1: Each pin input is synchronised and then accepted only after it has been stable for N clocks: N=2 when `filt_long_i`=0 and N=6 when it is 1. A pin pulse shorter than that window has no effect.
- R2: In two-wire mode, SDA falling while SCL is high (start) or SDA rising while SCL is high (stop) pulses `irq_bus_o`. A start sets `bus_busy_o` and a stop clears it. The pulse comes N+3 clocks after the pin change.
- R3: A two-wire frame is 9 bits. It sends `tx_data_i` MSB first and then `ack_level_i`, and it samples SDA on every SCL rise. `sda_oe_o`=1 means the line is pulled low. The byte received on rises 1 to 8, MSB first, appears on `rx_data_o`.
- R4: In two-wire mode the 9th sample decides the events: high pulses `irq_txnack_o`, low pulses both `irq_rxack_o` and `dma_req_o`.
- R5: In synchronous mode a frame is 8 bits, LSB first, with the data pin push-pull (`sda_oe_o`=1). At the 8th rise `irq_txnack_o` (transmit done), `irq_rxack_o` (receive done) and `dma_req_o` each pulse once.
- R6: In synchronous mode, each SCL rise at which the sampled SDA differs from the bit being sent pulses `irq_bus_o` once.
- R7: In two-wire mode, a data bit sent as 1 but sampled as 0 sets `arb_lost_o`. The flag stays set until `arb_clr_i` is asserted.
- R8: A transmit bit changes `sda_dly_i` clocks after the filtered SCL fall (0 = the same clock). The first fall after loading does not advance the bits.
- R9: While `en_i`=0 the data pin idles high: it is released in two-wire mode and driven to 1 in synchronous mode. `tx_ready_o` is 0.
- R10: In two-wire mode with `clk_wait_i`=1, `scl_oe_o` goes to 1 after the SCL fall that ends the 9th bit. It stays at 1 until `hold_rel_i` is pulsed.
- R11: `port_rd_o` returns the raw SDA pin in two-wire mode, or when `port_dir_i`=0. Otherwise it returns `port_latch_i`.
- R12: The block accepts a byte only on `tx_valid_i`&`tx_ready_o`, and `tx_ready_o` falls for the duration of the frame. `rx_valid_o` stays high until `rx_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Serial function enable |
| i2c_mode_i | input | 1 | 1 = two-wire mode, 0 = synchronous mode |
| filt_long_i | input | 1 | Glitch filter width select (0 short, 1 long) |
| sda_dly_i | input | DLY_W | SDA output delay in clocks after SCL fall |
| clk_wait_i | input | 1 | Hold SCL low after the 9th bit |
| hold_rel_i | input | 1 | Release the SCL hold |
| ack_level_i | input | 1 | Level sent in the acknowledge slot |
| arb_clr_i | input | 1 | Clear the arbitration-lost flag |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte can be accepted |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Received byte taken |
| sda_i | input | 1 | SDA pin level |
| sda_o | output | 1 | SDA output level |
| sda_oe_o | output | 1 | SDA output enable |
| scl_i | input | 1 | SCL pin level |
| scl_oe_o | output | 1 | Pull SCL low (clock hold) |
| port_dir_i | input | 1 | General-purpose direction setting of the SDA pin |
| port_latch_i | input | 1 | General-purpose output latch of the SDA pin |
| port_rd_o | output | 1 | Pin read value |
| irq_txnack_o | output | 1 | Transmit done / no-acknowledge pulse |
| irq_rxack_o | output | 1 | Receive done / acknowledge pulse |
| irq_bus_o | output | 1 | Collision / start-stop pulse |
| dma_req_o | output | 1 | DMA request pulse |
| bus_busy_o | output | 1 | Bus-busy flag |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |

## Verification
A pin change reaches the filtered level N+2 clocks later. Start and stop pulses and bus-busy updates follow one clock after that, at N+3. A transmit bit moves N+3+`sda_dly_i` clocks after the SCL pin falls. The bench counts exactly that many rising edges from the stimulus and samples at the falling edge just before and just after. It does this both for the start-detect latency at both filter widths and for a three-clock SDA delay. Frame results are pulses and held flags. The bench counts every event pulse at each clock and compares the counts and `rx_data_o` once the frame has settled, so that the checks do not depend on exact edge timing.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    MODE_SYNC = 1'b0,
    MODE_I2C  = 1'b1
  } sio_mode_e;

  typedef struct packed {
    logic txnack;
    logic rxack;
    logic bus;
    logic dma;
  } sio_evt_t;
endpackage

// File: rtl/sio_glitch_filter.sv
module sio_glitch_filter #(
  parameter int SHORT_N = 2,
  parameter int LONG_N  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_i,
  input  logic pin_i,
  output logic level_o
);
  localparam int CNT_W = $clog2(LONG_N + 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_N - 1);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_N - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim = long_i ? LIM_L : LIM_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      level_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] != level_o) begin
        if (cnt_q >= lim) begin
          level_o <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/sio_bus_monitor.sv
module sio_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic sda_q;

  assign start_o = enable_i & scl_i & sda_q & ~sda_i;
  assign stop_o  = enable_i & scl_i & ~sda_q & sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q  <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      sda_q <= sda_i;
      if (start_o)     busy_o <= 1'b1;
      else if (stop_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_out_delay.sv
module sio_out_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             pend_q;

  assign fire_o = (trig_i && dly_i == '0) || (pend_q && cnt_q == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (trig_i && dly_i != '0) begin
      cnt_q  <= dly_i;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q == DLY_W'(1)) pend_q <= 1'b0;
      else                    cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sio_i2c_shifter.sv
module sio_i2c_shifter
  import sio_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DLY_W   = 3,
  parameter int SHORT_N = 2,
  parameter int LONG_N  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              i2c_mode_i,
  input  logic              filt_long_i,
  input  logic [DLY_W-1:0]  sda_dly_i,
  input  logic              clk_wait_i,
  input  logic              hold_rel_i,
  input  logic              ack_level_i,
  input  logic              arb_clr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic              scl_i,
  output logic              scl_oe_o,
  input  logic              port_dir_i,
  input  logic              port_latch_i,
  output logic              port_rd_o,
  output logic              irq_txnack_o,
  output logic              irq_rxack_o,
  output logic              irq_bus_o,
  output logic              dma_req_o,
  output logic              bus_busy_o,
  output logic              arb_lost_o
);
  localparam int FW = DATA_W + 1;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LEN_I2C  = CW'(FW);
  localparam logic [CW-1:0] LEN_SYNC = CW'(DATA_W);

  sio_mode_e mode;
  logic      is_i2c;
  assign mode   = i2c_mode_i ? MODE_I2C : MODE_SYNC;
  assign is_i2c = (mode == MODE_I2C);

  // pin filters: index 0 = SCL, 1 = SDA
  logic [1:0] pin_raw, pin_flt;
  assign pin_raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_flt
    sio_glitch_filter #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_flt (
      .clk(clk), .rst_n(rst_n), .long_i(filt_long_i),
      .pin_i(pin_raw[g]), .level_o(pin_flt[g])
    );
  end

  logic scl_f, sda_f, scl_q, scl_rise, scl_fall;
  assign scl_f    = pin_flt[0];
  assign sda_f    = pin_flt[1];
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;

  logic start_det, stop_det;
  sio_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .enable_i(en_i & is_i2c),
    .scl_i(scl_f), .sda_i(sda_f),
    .start_o(start_det), .stop_o(stop_det), .busy_o(bus_busy_o)
  );

  logic          active;
  logic [CW-1:0] bit_cnt, flen;
  logic [DATA_W:0] tx_sh, rx_sh, rx_next;
  logic          cur_bit, out_bit, last_rise, apply, scl_hold;
  sio_evt_t      evt;

  assign flen    = is_i2c ? LEN_I2C : LEN_SYNC;
  assign cur_bit = is_i2c ? tx_sh[DATA_W] : tx_sh[0];
  assign out_bit = active ? cur_bit : 1'b1;
  assign rx_next = is_i2c ? {rx_sh[DATA_W-1:0], sda_f}
                          : {1'b0, sda_f, rx_sh[DATA_W-1:1]};
  assign last_rise = active & scl_rise & (bit_cnt == flen - 1'b1);

  sio_out_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .trig_i(en_i & active & scl_fall & (bit_cnt != '0)),
    .dly_i(sda_dly_i), .fire_o(apply)
  );

  assign tx_ready_o = en_i & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      active     <= 1'b0;
      bit_cnt    <= '0;
      tx_sh      <= '1;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      arb_lost_o <= 1'b0;
      scl_hold   <= 1'b0;
      evt        <= '0;
    end else begin
      scl_q <= scl_f;
      evt   <= '0;
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      if (arb_clr_i) arb_lost_o <= 1'b0;
      if (start_det || stop_det) evt.bus <= 1'b1;

      if (!en_i) begin
        active   <= 1'b0;
        scl_hold <= 1'b0;
      end else begin
        if (tx_valid_i && tx_ready_o) begin
          active  <= 1'b1;
          bit_cnt <= '0;
          tx_sh   <= is_i2c ? {tx_data_i, ack_level_i} : {1'b1, tx_data_i};
        end else if (active) begin
          if (scl_rise) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (!is_i2c && cur_bit != sda_f) evt.bus <= 1'b1;
            if (is_i2c && bit_cnt < LEN_SYNC && cur_bit && !sda_f)
              arb_lost_o <= 1'b1;
            if (last_rise) begin
              rx_data_o  <= is_i2c ? rx_next[DATA_W:1] : rx_next[DATA_W-1:0];
              rx_valid_o <= 1'b1;
              evt.txnack <= is_i2c ? sda_f : 1'b1;
              evt.rxack  <= is_i2c ? ~sda_f : 1'b1;
              evt.dma    <= is_i2c ? ~sda_f : 1'b1;
            end
          end
          if (apply) begin
            if (bit_cnt == flen) active <= 1'b0;
            else if (is_i2c)     tx_sh  <= {tx_sh[DATA_W-1:0], 1'b1};
            else                 tx_sh  <= {1'b1, tx_sh[DATA_W:1]};
          end
        end
        if (active && scl_fall && is_i2c && clk_wait_i && bit_cnt == LEN_I2C)
          scl_hold <= 1'b1;
        else if (hold_rel_i || !is_i2c)
          scl_hold <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!en_i) begin
      sda_o    = ~is_i2c;
      sda_oe_o = ~is_i2c;
    end else if (is_i2c) begin
      sda_o    = 1'b0;
      sda_oe_o = ~out_bit;
    end else begin
      sda_o    = out_bit;
      sda_oe_o = 1'b1;
    end
  end

  assign scl_oe_o     = scl_hold;
  assign port_rd_o    = (is_i2c || !port_dir_i) ? sda_i : port_latch_i;
  assign irq_txnack_o = evt.txnack;
  assign irq_rxack_o  = evt.rxack;
  assign irq_bus_o    = evt.bus;
  assign dma_req_o    = evt.dma;
endmodule

// File: rtl/sio_i2c_shifter_chk.sv
module sio_i2c_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic i2c_mode_i,
  input logic clk_wait_i,
  input logic arb_clr_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic rx_ready_i,
  input logic sda_o,
  input logic sda_oe_o,
  input logic scl_oe_o,
  input logic irq_txnack_o,
  input logic irq_rxack_o,
  input logic irq_bus_o,
  input logic bus_busy_o,
  input logic arb_lost_o
);
  AST_BUSY_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_o) |-> irq_bus_o); // R2
  AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode_i && irq_txnack_o) |-> !irq_rxack_o); // R4
  AST_ARB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o && !arb_clr_i) |=> arb_lost_o); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (sda_oe_o ? sda_o : 1'b1)); // R9
  AST_HOLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> $past(i2c_mode_i && clk_wait_i)); // R10
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o); // R12
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o); // R12
endmodule

bind sio_i2c_shifter sio_i2c_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .i2c_mode_i(i2c_mode_i),
  .clk_wait_i(clk_wait_i), .arb_clr_i(arb_clr_i),
  .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .sda_o(sda_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o),
  .irq_txnack_o(irq_txnack_o), .irq_rxack_o(irq_rxack_o),
  .irq_bus_o(irq_bus_o), .bus_busy_o(bus_busy_o), .arb_lost_o(arb_lost_o)
);

// File: tb/sio_i2c_shifter_tb.sv
`timescale 1ns/1ps
module sio_i2c_shifter_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic en = 1'b0, i2c = 1'b0, flong = 1'b0, cwait = 1'b0, hrel = 1'b0;
  logic ackl = 1'b1, aclr = 1'b0, txv = 1'b0, rxr = 1'b0;
  logic [2:0] dly = 3'd2;
  logic [7:0] txd = 8'h00;
  logic pdir = 1'b1, plat = 1'b0;
  logic bscl = 1'b1, bsda = 1'b1;
  logic txrdy, rxv, sdao, sdaoe, scloe, prd, ia, ib, ic, dreq, busy, arb;
  logic [7:0] rxd;
  logic sda_line, scl_line;

  assign sda_line = (sdaoe ? sdao : 1'b1) & bsda;
  assign scl_line = bscl & ~scloe;

  sio_i2c_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .i2c_mode_i(i2c), .filt_long_i(flong),
    .sda_dly_i(dly), .clk_wait_i(cwait), .hold_rel_i(hrel), .ack_level_i(ackl),
    .arb_clr_i(aclr), .tx_data_i(txd), .tx_valid_i(txv), .tx_ready_o(txrdy),
    .rx_data_o(rxd), .rx_valid_o(rxv), .rx_ready_i(rxr),
    .sda_i(sda_line), .sda_o(sdao), .sda_oe_o(sdaoe),
    .scl_i(scl_line), .scl_oe_o(scloe),
    .port_dir_i(pdir), .port_latch_i(plat), .port_rd_o(prd),
    .irq_txnack_o(ia), .irq_rxack_o(ib), .irq_bus_o(ic), .dma_req_o(dreq),
    .bus_busy_o(busy), .arb_lost_o(arb)
  );

  int n_a = 0, n_b = 0, n_c = 0, n_d = 0;
  always @(posedge clk) begin
    if (ia) n_a++;
    if (ib) n_b++;
    if (ic) n_c++;
    if (dreq) n_d++;
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {mode, tx byte, ack level, 9-bit responder pattern}
  localparam logic [18:0] VEC [7] = '{
    {1'b1, 8'hA5, 1'b1, 9'h1FF},
    {1'b1, 8'hFF, 1'b0, 9'h06B},
    {1'b1, 8'h3C, 1'b1, 9'h1FE},
    {1'b1, 8'h80, 1'b1, 9'h0FF},
    {1'b0, 8'h5A, 1'b0, 9'h1FF},
    {1'b0, 8'hF0, 1'b0, 9'h03C},
    {1'b0, 8'h01, 1'b0, 9'h1FF}
  };

  task automatic load(input logic [7:0] d);
    txd = d; txv = 1'b1;
    @(negedge clk);
    txv = 1'b0;
  endtask

  // two-wire frame: start, 9 bits, optional hold check, stop
  task automatic i2c_frame(input logic [7:0] d, input logic [8:0] resp,
                           input bit hold, input bit probe);
    bscl = 1'b1; bsda = 1'b0; wt(20);
    bscl = 1'b0; wt(20);
    load(d);
    for (int i = 8; i >= 0; i--) begin
      wt(10); bsda = resp[i]; wt(20);
      bscl = 1'b1; wt(40);
      bscl = 1'b0;
      if (probe && i == 8) begin
        wt(7);
        chk(sdaoe == 1'b1, "R8 sda held before delay", sdaoe, 1);
        wt(1);
        chk(sdaoe == 1'b0, "R8 sda moved after delay", sdaoe, 0);
      end
    end
    wt(30);
    if (hold) begin
      chk(scloe == 1'b1, "R10 scl held after 9th bit", scloe, 1);
      wt(20);
      chk(scloe == 1'b1, "R10 hold persists", scloe, 1);
      hrel = 1'b1; wt(1); hrel = 1'b0; wt(1);
      chk(scloe == 1'b0, "R10 hold released", scloe, 0);
    end
    bsda = 1'b0; wt(20);
    bscl = 1'b1; wt(20);
    bsda = 1'b1; wt(40);
  endtask

  task automatic sync_frame(input logic [7:0] d, input logic [8:0] resp);
    load(d);
    for (int i = 0; i < 8; i++) begin
      bscl = 1'b0; wt(10); bsda = resp[i]; wt(20);
      bscl = 1'b1; wt(40);
    end
    bscl = 1'b0; wt(30);
    bsda = 1'b1; bscl = 1'b1; wt(40);
  endtask

  task automatic run_vectors();
    for (int v = 0; v < 7; v++) begin
      logic [18:0] e;
      logic [8:0] tw, line;
      logic [7:0] exp_rx;
      int ea, eb, ec, a0, b0, c0, d0;
      bit earb;
      e = VEC[v];
      i2c = e[18]; ackl = e[9];
      aclr = 1'b1; wt(1); aclr = 1'b0; wt(2);
      a0 = n_a; b0 = n_b; c0 = n_c; d0 = n_d;
      if (e[18]) begin
        tw = {e[17:10], e[9]};
        line = tw & e[8:0];
        exp_rx = line[8:1];
        ea = line[0] ? 1 : 0; eb = line[0] ? 0 : 1; ec = 2;
        earb = |(tw[8:1] & ~e[8:1]);
        i2c_frame(e[17:10], e[8:0], 1'b0, 1'b0);
        chk(arb == earb, "R7 arbitration flag", arb, earb);
        chk(busy == 1'b0, "R2 busy cleared by stop", busy, 0);
      end else begin
        exp_rx = e[17:10] & e[7:0];
        ea = 1; eb = 1;
        ec = $countones(e[17:10] & ~e[7:0]);
        sync_frame(e[17:10], e[8:0]);
      end
      chk(rxv == 1'b1 && rxd == exp_rx, e[18] ? "R3 rx byte" : "R5 rx byte", rxd, exp_rx);
      chk(n_a - a0 == ea, e[18] ? "R4 nack event" : "R5 tx done event", n_a - a0, ea);
      chk(n_b - b0 == eb && n_d - d0 == eb, e[18] ? "R4 ack/dma event" : "R5 rx/dma event",
          n_d - d0, eb);
      chk(n_c - c0 == ec, e[18] ? "R2 start/stop events" : "R6 collision events", n_c - c0, ec);
      rxr = 1'b1; wt(1); rxr = 1'b0;
      chk(rxv == 1'b0, "R12 rx consumed", rxv, 0);
    end
  endtask

  task automatic start_latency(input bit lng, input int n);
    int c0;
    flong = lng; i2c = 1'b1; wt(10);
    c0 = n_c;
    bsda = 1'b0;
    wt(n + 2);
    chk(n_c == c0 && busy == 1'b0, "R2 no start before latency", n_c - c0, 0);
    wt(1);
    chk(ic == 1'b1 && busy == 1'b1, "R2 start at N+3", ic, 1);
    bsda = 1'b1; wt(12);
    chk(busy == 1'b0, "R2 stop clears busy", busy, 0);
  endtask

  task automatic run_all();
    int c0;
    wt(3);
    chk(txrdy == 1'b0 && sdaoe == 1'b1 && sdao == 1'b1, "R9 reset idle, disabled", sdao, 1);
    chk(rxv == 1'b0 && busy == 1'b0 && arb == 1'b0 && scloe == 1'b0,
        "R12 reset state", {rxv, busy, arb, scloe}, 0);
    rst_n = 1'b1; wt(2);
    i2c = 1'b1; wt(1);
    chk(sdaoe == 1'b0 && txrdy == 1'b0, "R9 disabled two-wire releases", sdaoe, 0);
    en = 1'b1; wt(1);
    chk(txrdy == 1'b1, "R12 ready when idle", txrdy, 1);

    run_vectors();

    start_latency(1'b0, 2);
    start_latency(1'b1, 6);

    // R1: glitch shorter than the long window is dropped
    flong = 1'b1; wt(10); c0 = n_c;
    bsda = 1'b0; wt(4); bsda = 1'b1; wt(20);
    chk(n_c == c0 && busy == 1'b0, "R1 short glitch ignored", n_c - c0, 0);
    flong = 1'b0; wt(10); c0 = n_c;
    bsda = 1'b0; wt(1); bsda = 1'b1; wt(20);
    chk(n_c == c0, "R1 one-clock glitch ignored", n_c - c0, 0);

    // R8: three-clock output delay probe, R12 rx hold without ready
    dly = 3'd3; ackl = 1'b1;
    i2c_frame(8'h40, 9'h1FF, 1'b0, 1'b1);
    wt(5);
    chk(rxv == 1'b1 && rxd == 8'h40, "R12 rx held without ready", rxd, 8'h40);
    rxr = 1'b1; wt(1); rxr = 1'b0;
    dly = 3'd2;

    // R10: clock hold
    cwait = 1'b1;
    i2c_frame(8'hC3, 9'h1FE, 1'b1, 1'b0);
    cwait = 1'b0;
    rxr = 1'b1; wt(1); rxr = 1'b0;

    // R7: clear of sticky flag
    i2c_frame(8'hFF, 9'h0FF, 1'b0, 1'b0);
    chk(arb == 1'b1, "R7 arb lost set", arb, 1);
    wt(10);
    chk(arb == 1'b1, "R7 arb stays set", arb, 1);
    aclr = 1'b1; wt(1); aclr = 1'b0;
    chk(arb == 1'b0, "R7 arb cleared", arb, 0);
    rxr = 1'b1; wt(1); rxr = 1'b0;

    // R11: pin read mux
    pdir = 1'b1; plat = 1'b0; i2c = 1'b1; wt(1);
    chk(prd == 1'b1, "R11 two-wire reads pin", prd, 1);
    i2c = 1'b0; wt(1);
    chk(prd == 1'b0, "R11 output dir reads latch", prd, 0);
    pdir = 1'b0; wt(1);
    chk(prd == 1'b1, "R11 input dir reads pin", prd, 1);

    // R9: disable in synchronous mode drives high
    en = 1'b0; wt(1);
    chk(sdaoe == 1'b1 && sdao == 1'b1 && txrdy == 1'b0, "R9 sync disabled high", sdao, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule